// File: doc/BRIEF.md
# System Clock Divider and Block Clock Gating Control

This block picks the main clock from a small group of source tick inputs, divides it by a programmable 8-bit ratio, and produces the system clock as a stream of one-cycle clock-enable pulses. It also holds a set of per-block clock enables: one for the core, bus bridge and system control logic, one for the ROM and one for the RAM. Every signal is sampled on one fast clock `clk`. Each clock source appears as a tick-enable input in that domain, so a "main-clock cycle" is one cycle in which the selected source tick is high.

Software configures the block through a small word-addressed register port with a single-cycle write and a registered read. A newly written source selection waits in a pending register. It becomes active only when an explicit commit is written. A new divide ratio takes effect at the end of the current divided period. The per-block enables move to their programmed values only at a divided-clock boundary, so a gated block never receives a partial period.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the divider holds 1, the update bit holds 0, the pending and active source selects hold 0, and all three block enables are 1. `sys_ce_o` and `reg_rdata_o` are 0 while reset is asserted.
- R2: A main tick is a cycle with `src_tick_i[active select]` high. With divider N in 1..255, `sys_ce_o` rises for one cycle, one cycle after every Nth main tick. N = 1 gives one pulse for every main tick.
- R3: While the active divider is 0, `sys_ce_o` stays low. After a non-zero value is written, the first main tick loads it and counting restarts from zero.
- R4: A divider write does not change the length of the period in progress. The new value governs the periods that start after the next pulse.
- R5: The active select is loaded from the pending select only by a write to the update register that takes its bit 0 from 0 to 1. Writing 0, or writing 1 again while it already holds 1, leaves the active source unchanged.
- R6: Register words are: address 0 = pending source select in bits [1:0], address 1 = update bit in bit 0, address 2 = divider in bits [7:0], address 3 = block enables in bits [2:0] (bit 0 core/bridge, bit 1 ROM, bit 2 RAM). Unused bits read 0. `reg_rdata_o` presents the word addressed in the previous cycle, as it was before any write at that same edge.
- R7: Enable bit 0 is read-only. It reads 1 and `blk_en_o[0]` stays 1 whatever is written.
- R8: `blk_en_o[2:1]` take the programmed enable bits only at the edge that raises `sys_ce_o`. At all other times they hold their value.
- R9: A select value with no matching source (3 with three sources) yields no main ticks, so `sys_ce_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | 3 | Per-source tick enables, one per candidate main clock |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| sys_ce_o | output | 1 | System clock-enable pulse |
| blk_en_o | output | 3 | Per-block clock enables (core/bridge, ROM, RAM) |

## Verification
The collision of interest is a divider or enable write that lands on the same edge as a divided-period boundary. The old ratio and the old enable bits must govern that boundary, and the new ones only the next. Directed steps drive the write in the very cycle a pulse is seen. Seeded random writes with small divisors then cause many more such overlaps. Each case is judged against a cycle model in the bench, built from the requirements, that updates its divider, its enables and its read data from the pre-edge state.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    A_SRCSEL = 2'd0,
    A_COMMIT = 2'd1,
    A_RATIO  = 2'd2,
    A_GATES  = 2'd3
  } reg_addr_e;

  // Rising edge of the stored commit bit.
  function automatic logic commit_edge(input logic stored, input logic written);
    return written && !stored;
  endfunction

endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 8,
  parameter int NUM_BLK = 3,
  parameter int DATA_W  = 32,
  parameter int DIV_RST = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [REG_AW-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [SEL_W-1:0]   sel_pend,
  output logic [DIV_W-1:0]   div_reg,
  output logic [NUM_BLK-1:0] en_reg,
  output logic               commit,
  output logic [DATA_W-1:0]  rdata
);

  reg_addr_e   a_dec;
  logic        wr_sel, wr_upd, wr_div, wr_en;
  logic        upd_q;
  logic [DATA_W-1:0] rd_next;
  logic        unused_wdata;

  assign a_dec  = reg_addr_e'(addr);
  assign wr_sel = we && (a_dec == A_SRCSEL);
  assign wr_upd = we && (a_dec == A_COMMIT);
  assign wr_div = we && (a_dec == A_RATIO);
  assign wr_en  = we && (a_dec == A_GATES);
  assign commit = wr_upd && commit_edge(upd_q, wdata[0]);
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_pend <= '0;
      upd_q    <= 1'b0;
      div_reg  <= DIV_W'(DIV_RST);
    end else begin
      if (wr_sel) sel_pend <= wdata[SEL_W-1:0];
      if (wr_upd) upd_q    <= wdata[0];
      if (wr_div) div_reg  <= wdata[DIV_W-1:0];
    end
  end

  // Bit 0 is fixed on; the rest are writable and reset on.
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_en
    if (g == 0) begin : g_fixed
      assign en_reg[g] = 1'b1;
    end else begin : g_rw
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b1;
        else if (wr_en) q <= wdata[g];
      end
      assign en_reg[g] = q;
    end
  end

  always_comb begin
    rd_next = '0;
    unique case (a_dec)
      A_SRCSEL: rd_next = DATA_W'(sel_pend);
      A_COMMIT: rd_next = DATA_W'(upd_q);
      A_RATIO:  rd_next = DATA_W'(div_reg);
      A_GATES:  rd_next = DATA_W'(en_reg);
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

endmodule

// File: rtl/sysclk_srcsel.sv
module sysclk_srcsel #(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [SEL_W-1:0]   sel_pend,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [SEL_W-1:0]   sel_act,
  output logic               main_tick
);

  localparam int NPAD = 1 << SEL_W;

  logic [NPAD-1:0] tick_pad;

  // Select codes past the last source map to a silent zero input.
  assign tick_pad  = NPAD'(src_tick);
  assign main_tick = tick_pad[sel_act];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_act <= '0;
    else if (commit) sel_act <= sel_pend;
  end

endmodule

// File: rtl/sysclk_div.sv
module sysclk_div #(
  parameter int DIV_W   = 8,
  parameter int DIV_RST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_tick,
  input  logic [DIV_W-1:0] div_reg,
  output logic [DIV_W-1:0] div_act,
  output logic             boundary,
  output logic             sys_ce
);

  logic [DIV_W-1:0] cnt;

  function automatic logic period_last(input logic [DIV_W-1:0] c,
                                       input logic [DIV_W-1:0] n);
    return (n != '0) && (c == n - DIV_W'(1));
  endfunction

  assign boundary = main_tick && period_last(cnt, div_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_act <= DIV_W'(DIV_RST);
      sys_ce  <= 1'b0;
    end else begin
      sys_ce <= boundary;
      if (main_tick) begin
        if (div_act == '0) begin
          div_act <= div_reg;
          cnt     <= '0;
        end else if (boundary) begin
          div_act <= div_reg;
          cnt     <= '0;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sysclk_gate.sv
module sysclk_gate #(
  parameter int NUM_BLK = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary,
  input  logic [NUM_BLK-1:0] en_reg,
  output logic [NUM_BLK-1:0] blk_en
);

  logic unused_en0;
  assign unused_en0 = en_reg[0];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    if (g == 0) begin : g_on
      assign blk_en[g] = 1'b1;
    end else begin : g_q
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= 1'b1;
        else if (boundary) q <= en_reg[g];
      end
      assign blk_en[g] = q;
    end
  end

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int DIV_W   = 8,
  parameter int NUM_BLK = 3,
  parameter int DATA_W  = 32,
  parameter int DIV_RST = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               sys_ce_o,
  output logic [NUM_BLK-1:0] blk_en_o
);

  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [SEL_W-1:0]   sel_pend_w, sel_act_w;
  logic [DIV_W-1:0]   div_reg_w, div_act_w;
  logic [NUM_BLK-1:0] en_reg_w;
  logic               commit_w, main_tick_w, boundary_w;

  sysclk_regs #(
    .SEL_W(SEL_W), .DIV_W(DIV_W), .NUM_BLK(NUM_BLK),
    .DATA_W(DATA_W), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .sel_pend(sel_pend_w), .div_reg(div_reg_w),
    .en_reg(en_reg_w), .commit(commit_w), .rdata(reg_rdata_o)
  );

  sysclk_srcsel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_src (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .sel_pend(sel_pend_w),
    .src_tick(src_tick_i), .sel_act(sel_act_w), .main_tick(main_tick_w)
  );

  sysclk_div #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_div (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick_w), .div_reg(div_reg_w),
    .div_act(div_act_w), .boundary(boundary_w), .sys_ce(sys_ce_o)
  );

  sysclk_gate #(.NUM_BLK(NUM_BLK)) u_gate (
    .clk(clk), .rst_n(rst_n), .boundary(boundary_w), .en_reg(en_reg_w),
    .blk_en(blk_en_o)
  );

endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 8,
  parameter int NUM_BLK = 3,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               main_tick,
  input logic               commit,
  input logic [SEL_W-1:0]   sel_act,
  input logic [DIV_W-1:0]   div_act,
  input logic               sys_ce,
  input logic [NUM_BLK-1:0] blk_en,
  input logic [1:0]         reg_addr,
  input logic [DATA_W-1:0]  reg_rdata
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_CE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    sys_ce |-> $past(main_tick)); // R2

  AST_ZERO_RATIO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act == '0) |=> !sys_ce); // R3

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sel_act)); // R5

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:DIV_W] == '0); // R6

  AST_CORE_BIT_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    ($past(reg_addr) == 2'd3) |-> reg_rdata[0]); // R7

  AST_CORE_EN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    blk_en[0]); // R7

  AST_GATES_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n || !seen)
    !$stable(blk_en) |-> sys_ce); // R8

endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(
  .SEL_W(SEL_W), .DIV_W(DIV_W), .NUM_BLK(NUM_BLK), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .main_tick(main_tick_w), .commit(commit_w),
  .sel_act(sel_act_w), .div_act(div_act_w), .sys_ce(sys_ce_o),
  .blk_en(blk_en_o), .reg_addr(reg_addr_i), .reg_rdata(reg_rdata_o)
);

// File: tb/tb_sysclk_ctrl.sv
module tb_sysclk_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [1:0] AD_SEL = 2'd0, AD_UPD = 2'd1, AD_DIV = 2'd2, AD_EN = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src = 3'b000;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_ce;
  logic [2:0]  blk_en;

  int n_chk = 0, n_fail = 0, cyc = 0, src_mode = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  sysclk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sys_ce_o(sys_ce), .blk_en_o(blk_en)
  );

  // Reference model built from the requirements.
  logic [1:0]  m_pend, m_act;
  logic        m_upd, m_ce;
  logic [7:0]  m_div, m_dact, m_cnt;
  logic [2:1]  m_en, m_blk;
  logic [31:0] m_rd;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      AD_SEL:  return {30'd0, m_pend};
      AD_UPD:  return {31'd0, m_upd};
      AD_DIV:  return {24'd0, m_div};
      default: return {29'd0, m_en, 1'b1};
    endcase
  endfunction

  function automatic logic tick_of(input logic [2:0] s, input logic [1:0] sel);
    return (sel == 2'd3) ? 1'b0 : s[sel];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 0; m_act <= 0; m_upd <= 0; m_ce <= 0;
      m_div <= 8'd1; m_dact <= 8'd1; m_cnt <= 0;
      m_en <= 2'b11; m_blk <= 2'b11; m_rd <= 0;
    end else begin
      logic t, b;
      t = tick_of(src, m_act);
      b = t && (m_dact != 0) && (m_cnt == m_dact - 8'd1);
      m_ce <= b;
      m_rd <= exp_read(addr);
      if (b) m_blk <= m_en;
      if (t) begin
        if (m_dact == 0 || b) begin m_dact <= m_div; m_cnt <= 0; end
        else m_cnt <= m_cnt + 8'd1;
      end
      if (we) begin
        case (addr)
          AD_SEL: m_pend <= wdata[1:0];
          AD_UPD: begin
            if (wdata[0] && !m_upd) m_act <= m_pend;
            m_upd <= wdata[0];
          end
          AD_DIV: m_div <= wdata[7:0];
          default: m_en <= wdata[2:1];
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check(sys_ce == m_ce, "R2 R3 R4 R5 R9 sys_ce model", 32'(sys_ce), 32'(m_ce));
      check(blk_en == {m_blk, 1'b1}, "R7 R8 blk_en model", 32'(blk_en), {29'd0, m_blk, 1'b1});
      check(rdata == m_rd, "R6 rdata model", rdata, m_rd);
    end
  end

  task automatic step();
    @(negedge clk);
    cyc++;
    case (src_mode)
      0: src = 3'b001;
      1: src = 3'b111;
      default: src = {(cyc % 3) == 0, 1'($urandom % 2), 1'b1};
    endcase
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step(); we = 1'b1; addr = a; wdata = d;
    step(); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    step(); addr = a;
    step(); v = rdata;
  endtask

  task automatic wait_ce();
    do step(); while (!sys_ce);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin step(); n++; end while (!sys_ce);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n, hits;
    void'($urandom(32'd20240611));
    repeat (3) step();
    check(sys_ce == 1'b0, "R1 ce in reset", 32'(sys_ce), 0);
    check(blk_en == 3'b111, "R1 blk_en in reset", 32'(blk_en), 7);
    check(rdata == 0, "R1 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    rd(AD_DIV, v); check(v == 1, "R1 divider reset", v, 1);
    rd(AD_UPD, v); check(v == 0, "R1 update reset", v, 0);
    rd(AD_EN, v);  check(v == 7, "R1 enables reset", v, 7);
    rd(AD_SEL, v); check(v == 0, "R1 select reset", v, 0);

    // R2: divide by one follows every tick
    hits = 0;
    repeat (10) begin step(); if (sys_ce) hits++; end
    check(hits == 10, "R2 divide by 1", 32'(hits), 10);

    // R2: divide by five
    wr(AD_DIV, 5);
    wait_ce(); wait_ce();
    gap(n); check(n == 5, "R2 divide by 5 period", 32'(n), 5);

    // R4: write in the pulse cycle leaves the running period intact
    wait_ce();
    we = 1'b1; addr = AD_DIV; wdata = 3;
    step(); we = 1'b0; n = 1;
    while (!sys_ce) begin step(); n++; end
    check(n == 5, "R4 running period kept", 32'(n), 5);
    gap(n); check(n == 3, "R4 new ratio applied", 32'(n), 3);

    // R3: zero stops, non-zero restarts
    wr(AD_DIV, 0);
    repeat (10) step();
    hits = 0;
    repeat (300) begin step(); if (sys_ce) hits++; end
    check(hits == 0, "R3 ratio zero silent", 32'(hits), 0);
    wr(AD_DIV, 2);
    wait_ce();
    gap(n); check(n == 2, "R3 restart ratio 2", 32'(n), 2);

    // R8 + R7: enables change only at the boundary
    wr(AD_DIV, 4);
    wait_ce(); wait_ce();
    we = 1'b1; addr = AD_EN; wdata = 32'h0;
    step(); we = 1'b0;
    step();
    check(blk_en == 3'b111, "R8 enables held mid-period", 32'(blk_en), 7);
    wait_ce();
    check(blk_en == 3'b001, "R8 enables at boundary", 32'(blk_en), 1);
    rd(AD_EN, v); check(v == 1, "R7 core bit reads one", v, 1);
    wr(AD_EN, 32'hFFFF_FFFF);
    rd(AD_EN, v); check(v == 7, "R6 enable reserved bits", v, 7);
    wait_ce();
    check(blk_en == 3'b111, "R8 enables restored", 32'(blk_en), 7);

    // R5: commit only on a 0-to-1 update write
    wr(AD_DIV, 1);
    wait_ce(); wait_ce();
    wr(AD_SEL, 1);
    hits = 0;
    repeat (5) begin step(); if (sys_ce) hits++; end
    check(hits == 5, "R5 pending select inactive", 32'(hits), 5);
    wr(AD_UPD, 1);
    step();
    hits = 0;
    repeat (10) begin step(); if (sys_ce) hits++; end
    check(hits == 0, "R5 commit moved to silent source", 32'(hits), 0);
    wr(AD_SEL, 0);
    wr(AD_UPD, 1);
    hits = 0;
    repeat (10) begin step(); if (sys_ce) hits++; end
    check(hits == 0, "R5 repeated one no commit", 32'(hits), 0);
    wr(AD_UPD, 0);
    hits = 0;
    repeat (5) begin step(); if (sys_ce) hits++; end
    check(hits == 0, "R5 zero write no commit", 32'(hits), 0);
    wr(AD_UPD, 1);
    step();
    check(sys_ce == 1'b1, "R5 commit back to source 0", 32'(sys_ce), 1);

    // R9: select with no source
    src_mode = 1;
    wr(AD_SEL, 32'hFFFF_FFFF);
    rd(AD_SEL, v); check(v == 3, "R6 select field width", v, 3);
    wr(AD_UPD, 0); wr(AD_UPD, 1);
    step();
    hits = 0;
    repeat (10) begin step(); if (sys_ce) hits++; end
    check(hits == 0, "R9 missing source silent", 32'(hits), 0);
    wr(AD_DIV, 32'hFFFF_FFFF);
    rd(AD_DIV, v); check(v == 255, "R6 divider reserved bits", v, 255);
    wr(AD_SEL, 0); wr(AD_UPD, 0); wr(AD_UPD, 1);
    wr(AD_DIV, 2);

    // Random phase against the model
    src_mode = 2;
    for (int i = 0; i < 6000; i++) begin
      step();
      if ($urandom % 5 == 0) begin
        we = 1'b1;
        addr = 2'($urandom % 4);
        case (addr)
          AD_DIV:  wdata = ($urandom % 16 == 0) ? $urandom : 32'($urandom % 6);
          AD_SEL:  wdata = ($urandom % 8 == 0) ? 32'd3 : 32'($urandom % 3);
          default: wdata = $urandom;
        endcase
      end else begin
        we = 1'b0;
        addr = 2'($urandom % 4);
      end
    end
    we = 1'b0;
    repeat (4) step();
    finish_run();
  end

endmodule